// File: doc/BRIEF.md
# SD Host Error Interrupt Status

This block keeps the sticky error flags for one channel of an SD/MMC host controller. The command, data, auto-CMD12 and scatter-gather DMA engines each report faults as single-cycle event pulses or as small qualified samples. Examples of such samples are a returned write CRC token, an observed end bit, or a fetched descriptor's valid flag. The block turns these into set requests for fixed positions of a 16-bit status word.

A set request only lands in the status word when the matching bit of a status-enable mask is 1. Once a flag has landed, it stays set until software writes a 1 to that position through a plain register write port. A second mask, the signal-enable mask, picks which latched flags raise the level interrupt output. That output is registered and follows the status word and the mask one cycle later.

The auto-CMD12 summary flag works differently from the others. It is set when any bit of the auto-CMD12 sub-status vector rises from 0 to 1. The current-limit position and the upper six positions are tied to 0.

Top module: `sd_err_status`

## Requirements
- R1: After a synchronous active-high reset, `err_status` is 16'h0000 and `err_irq` is 0.
- R2: With the matching status-enable bit at 1, each event sets its flag on the next clock edge: `cmd_err_ev[3:0]` sets bits 3:0, `dat_timeout_ev` sets bit 4, `dat_crc_ev` sets bit 5, `rd_end_bit_err_ev` sets bit 6 and `adma_err_ev` sets bit 9.
- R3: When `tok_valid` is 1, a write CRC token other than 3'b010 sets bit 5, and a token end bit of 0 sets bit 6. A token of 3'b010 with end bit 1 sets nothing.
- R4: When `desc_fetch` is 1 and `desc_valid` is 0, bit 9 is set. A fetch with `desc_valid` at 1 sets nothing.
- R5: Bit 8 is set on the edge after any bit of `acmd12_err` changes from 0 to 1. A vector that stays high or falls sets nothing. The stored copy of the previous vector resets to all zeros.
- R6: A flag whose `stat_en` bit is 0 never latches. `sig_en` has no effect on latching.
- R7: A register write with a 1 in a position clears that flag. A 0 leaves it unchanged, and several flags may be cleared by one write.
- R8: If a set request and a write-1 clear hit the same flag in the same cycle, the flag ends at 1.
- R9: Bit 7 and bits 15:10 always read 0, whatever events or writes occur.
- R10: `err_irq` equals, one cycle later, the OR over all positions of `err_status & sig_en`.
- R11: A latched flag stays 1 after its event goes away, until it is cleared by a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_err_ev | input | 4 | Command-path error pulses for bits 3:0 |
| dat_timeout_ev | input | 1 | Data or busy timeout pulse |
| dat_crc_ev | input | 1 | Read data CRC mismatch pulse |
| rd_end_bit_err_ev | input | 1 | Read data end bit seen as 0 |
| tok_valid | input | 1 | Write CRC status token sample is valid |
| tok_bits | input | 3 | Returned write CRC status token |
| tok_end_bit | input | 1 | End bit that follows the token |
| adma_err_ev | input | 1 | DMA engine error pulse |
| desc_fetch | input | 1 | Descriptor examined in fetch state |
| desc_valid | input | 1 | Valid flag of that descriptor |
| acmd12_err | input | 6 | Auto-CMD12 error sub-status vector |
| reg_wr | input | 1 | Status register write strobe |
| reg_wdata | input | 16 | Write data, 1 clears the flag |
| stat_en | input | 16 | Per-bit latch enable |
| sig_en | input | 16 | Per-bit interrupt enable |
| err_status | output | 16 | Sticky error flags |
| err_irq | output | 1 | Registered level interrupt |

## Verification
The assertions assume that the reset is held for at least one clock edge before any check counts. They also assume that events and writes are stable around each rising edge. The bench drives every input on the falling edge, so each sample is taken half a cycle away from the edge that uses it. Auto-CMD12 edges are judged against a copy of the vector that the checker itself keeps, so they do not depend on the design's own register. The stimulus mixes each event with masks on and off, sets and clears in the same cycle, and vectors that rise, stay high and fall.

// File: rtl/sd_err_pkg.sv
package sd_err_pkg;
  localparam int unsigned REG_W   = 16;
  localparam int unsigned ACMD_W  = 6;
  localparam int unsigned CMD_N   = 4;
  localparam int unsigned B_TOUT  = 4;
  localparam int unsigned B_CRC   = 5;
  localparam int unsigned B_ENDB  = 6;
  localparam int unsigned B_ILIM  = 7;
  localparam int unsigned B_ACMD  = 8;
  localparam int unsigned B_ADMA  = 9;
  localparam logic [2:0]  TOK_OK  = 3'b010;
  // positions that hold a flop; everything else is tied to zero
  localparam logic [REG_W-1:0] IMPL_MASK =
      (REG_W'(1) << B_ADMA) | (REG_W'(1) << B_ACMD) | (REG_W'(1) << B_ENDB) |
      (REG_W'(1) << B_CRC)  | (REG_W'(1) << B_TOUT) | REG_W'((1 << CMD_N) - 1);
endpackage

// File: rtl/sd_err_event_map.sv
module sd_err_event_map
  import sd_err_pkg::*;
#(
  parameter int unsigned W   = REG_W,
  parameter int unsigned AW  = ACMD_W,
  parameter int unsigned CN  = CMD_N
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CN-1:0] cmd_err_ev,
  input  logic          dat_timeout_ev,
  input  logic          dat_crc_ev,
  input  logic          rd_end_bit_err_ev,
  input  logic          tok_valid,
  input  logic [2:0]    tok_bits,
  input  logic          tok_end_bit,
  input  logic          adma_err_ev,
  input  logic          desc_fetch,
  input  logic          desc_valid,
  input  logic [AW-1:0] acmd12_err,
  output logic [W-1:0]  set_req
);
  logic [AW-1:0] acmd_prev_q;
  logic          acmd_rise;
  logic          tok_crc_bad;
  logic          tok_end_bad;
  logic          desc_bad;

  always_ff @(posedge clk) begin
    if (rst) acmd_prev_q <= '0;
    else     acmd_prev_q <= acmd12_err;
  end

  always_comb begin
    acmd_rise   = |(acmd12_err & ~acmd_prev_q);
    tok_crc_bad = tok_valid && (tok_bits != TOK_OK);
    tok_end_bad = tok_valid && !tok_end_bit;
    desc_bad    = desc_fetch && !desc_valid;
    set_req     = '0;
    set_req[CN-1:0] = cmd_err_ev;
    set_req[B_TOUT] = dat_timeout_ev;
    set_req[B_CRC]  = dat_crc_ev || tok_crc_bad;
    set_req[B_ENDB] = rd_end_bit_err_ev || tok_end_bad;
    set_req[B_ACMD] = acmd_rise;
    set_req[B_ADMA] = adma_err_ev || desc_bad;
  end
endmodule

// File: rtl/sd_err_sticky_bank.sv
module sd_err_sticky_bank #(
  parameter int unsigned    W    = 16,
  parameter logic [W-1:0]   IMPL = '1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_req,
  input  logic [W-1:0] stat_en,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] flags
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (IMPL[i]) begin : g_ff
      logic q;
      always_ff @(posedge clk) begin
        if (rst)                        q <= 1'b0;
        else if (set_req[i] && stat_en[i]) q <= 1'b1;
        else if (wr && wdata[i])        q <= 1'b0;
      end
      assign flags[i] = q;
    end else begin : g_zero
      assign flags[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sd_err_irq_gen.sv
module sd_err_irq_gen #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] flags,
  input  logic [W-1:0] sig_en,
  output logic         irq
);
  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= |(flags & sig_en);
  end
endmodule

// File: rtl/sd_err_status.sv
module sd_err_status
  import sd_err_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [CMD_N-1:0]  cmd_err_ev,
  input  logic              dat_timeout_ev,
  input  logic              dat_crc_ev,
  input  logic              rd_end_bit_err_ev,
  input  logic              tok_valid,
  input  logic [2:0]        tok_bits,
  input  logic              tok_end_bit,
  input  logic              adma_err_ev,
  input  logic              desc_fetch,
  input  logic              desc_valid,
  input  logic [ACMD_W-1:0] acmd12_err,
  input  logic              reg_wr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic [REG_W-1:0]  stat_en,
  input  logic [REG_W-1:0]  sig_en,
  output logic [REG_W-1:0]  err_status,
  output logic              err_irq
);
  logic [REG_W-1:0] set_req;

  sd_err_event_map #(.W(REG_W), .AW(ACMD_W), .CN(CMD_N)) u_map (
    .clk(clk), .rst(rst),
    .cmd_err_ev(cmd_err_ev), .dat_timeout_ev(dat_timeout_ev),
    .dat_crc_ev(dat_crc_ev), .rd_end_bit_err_ev(rd_end_bit_err_ev),
    .tok_valid(tok_valid), .tok_bits(tok_bits), .tok_end_bit(tok_end_bit),
    .adma_err_ev(adma_err_ev), .desc_fetch(desc_fetch), .desc_valid(desc_valid),
    .acmd12_err(acmd12_err), .set_req(set_req)
  );

  sd_err_sticky_bank #(.W(REG_W), .IMPL(IMPL_MASK)) u_bank (
    .clk(clk), .rst(rst), .set_req(set_req), .stat_en(stat_en),
    .wr(reg_wr), .wdata(reg_wdata), .flags(err_status)
  );

  sd_err_irq_gen #(.W(REG_W)) u_irq (
    .clk(clk), .rst(rst), .flags(err_status), .sig_en(sig_en), .irq(err_irq)
  );
endmodule

// File: rtl/sd_err_status_chk.sv
module sd_err_status_chk
  import sd_err_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              dat_timeout_ev,
  input logic [ACMD_W-1:0] acmd12_err,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic [REG_W-1:0]  stat_en,
  input logic [REG_W-1:0]  sig_en,
  input logic [REG_W-1:0]  err_status,
  input logic              err_irq
);
  logic [ACMD_W-1:0] seen_acmd;
  always_ff @(posedge clk) begin
    if (rst) seen_acmd <= '0;
    else     seen_acmd <= acmd12_err;
  end

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (err_status[REG_W-1:10] == '0) && !err_status[B_ILIM]); // R9

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (err_irq == |($past(err_status) & $past(sig_en)))); // R10

  AST_FALL_NEEDS_WRITE: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(err_status) & ~err_status) &
               ~($past(reg_wr) ? $past(reg_wdata) : '0)) == '0)); // R7

  AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (dat_timeout_ev && stat_en[B_TOUT]) |=> err_status[B_TOUT]); // R8

  AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (!stat_en[B_TOUT] && !err_status[B_TOUT]) |=> !err_status[B_TOUT]); // R6

  AST_ACMD_RISE: assert property (@(posedge clk) disable iff (rst)
    ((|(acmd12_err & ~seen_acmd)) && stat_en[B_ACMD]) |=> err_status[B_ACMD]); // R5
endmodule

bind sd_err_status sd_err_status_chk u_chk (
  .clk(clk), .rst(rst), .dat_timeout_ev(dat_timeout_ev), .acmd12_err(acmd12_err),
  .reg_wr(reg_wr), .reg_wdata(reg_wdata), .stat_en(stat_en), .sig_en(sig_en),
  .err_status(err_status), .err_irq(err_irq)
);

// File: tb/sd_err_status_tb.sv
module sd_err_status_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  cmd_err_ev;
  logic        dat_timeout_ev, dat_crc_ev, rd_end_bit_err_ev;
  logic        tok_valid, tok_end_bit;
  logic [2:0]  tok_bits;
  logic        adma_err_ev, desc_fetch, desc_valid;
  logic [5:0]  acmd12_err;
  logic        reg_wr;
  logic [15:0] reg_wdata, stat_en, sig_en;
  logic [15:0] err_status;
  logic        err_irq;

  int tests = 0;
  int fails = 0;
  logic [15:0] m_st;
  logic        m_irq;
  logic [5:0]  m_prev;

  always #5 clk = ~clk;

  sd_err_status u_dut (
    .clk(clk), .rst(rst), .cmd_err_ev(cmd_err_ev), .dat_timeout_ev(dat_timeout_ev),
    .dat_crc_ev(dat_crc_ev), .rd_end_bit_err_ev(rd_end_bit_err_ev),
    .tok_valid(tok_valid), .tok_bits(tok_bits), .tok_end_bit(tok_end_bit),
    .adma_err_ev(adma_err_ev), .desc_fetch(desc_fetch), .desc_valid(desc_valid),
    .acmd12_err(acmd12_err), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .stat_en(stat_en), .sig_en(sig_en), .err_status(err_status), .err_irq(err_irq)
  );

  task automatic idle_inputs();
    cmd_err_ev = '0; dat_timeout_ev = 0; dat_crc_ev = 0; rd_end_bit_err_ev = 0;
    tok_valid = 0; tok_bits = 3'b010; tok_end_bit = 1; adma_err_ev = 0;
    desc_fetch = 0; desc_valid = 1; reg_wr = 0; reg_wdata = '0;
  endtask

  // one clock: model computes from the inputs in place, then compare after the edge
  task automatic step(input string req);
    logic [15:0] setv;
    logic [15:0] nst;
    setv = 16'h0;
    for (int i = 0; i < 4; i++) if (cmd_err_ev[i]) setv[i] = 1'b1;
    if (dat_timeout_ev) setv[4] = 1'b1;
    if (dat_crc_ev || (tok_valid && tok_bits != 3'b010)) setv[5] = 1'b1;
    if (rd_end_bit_err_ev || (tok_valid && !tok_end_bit)) setv[6] = 1'b1;
    for (int i = 0; i < 6; i++) if (acmd12_err[i] && !m_prev[i]) setv[8] = 1'b1;
    if (adma_err_ev || (desc_fetch && !desc_valid)) setv[9] = 1'b1;
    setv = setv & stat_en;
    nst = m_st;
    if (reg_wr) nst = nst & ~reg_wdata;
    nst = (nst | setv) & 16'h037F;
    m_irq  = (m_st & sig_en) != 0;
    m_st   = nst;
    m_prev = acmd12_err;
    @(posedge clk);
    @(negedge clk);
    tests++;
    if (err_status !== m_st || err_irq !== m_irq) begin
      fails++;
      $display("[TB] FAIL %s status=%h exp=%h irq=%b exp=%b", req, err_status, m_st, err_irq, m_irq);
    end
    idle_inputs();
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("[TB] FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    idle_inputs();
    acmd12_err = '0; stat_en = 16'hFFFF; sig_en = 16'h0000;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_st = '0; m_irq = 0; m_prev = '0;
    tests++;
    if (err_status !== 16'h0 || err_irq !== 1'b0) begin
      fails++;
      $display("[TB] FAIL R1 status=%h exp=0000 irq=%b exp=0", err_status, err_irq);
    end
    step("R1");
    // R2 single events
    cmd_err_ev = 4'b0101; step("R2");
    dat_timeout_ev = 1; step("R2");
    step("R11");
    reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    dat_crc_ev = 1; step("R2");
    rd_end_bit_err_ev = 1; step("R2");
    adma_err_ev = 1; step("R2");
    reg_wr = 1; reg_wdata = 16'h0060; step("R7");
    reg_wr = 1; reg_wdata = 16'h0000; step("R7");
    reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    // R3 write token
    tok_valid = 1; tok_bits = 3'b010; tok_end_bit = 1; step("R3");
    tok_valid = 1; tok_bits = 3'b101; tok_end_bit = 1; step("R3");
    tok_valid = 1; tok_bits = 3'b010; tok_end_bit = 0; step("R3");
    tok_valid = 0; tok_bits = 3'b111; tok_end_bit = 0; step("R3");
    reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    // R4 descriptor
    desc_fetch = 1; desc_valid = 1; step("R4");
    desc_fetch = 1; desc_valid = 0; step("R4");
    reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    // R5 auto-CMD12 sub-status
    acmd12_err = 6'b000010; step("R5");
    reg_wr = 1; reg_wdata = 16'h0100; step("R5");
    step("R5");
    acmd12_err = 6'b000000; step("R5");
    acmd12_err = 6'b100010; step("R5");
    reg_wr = 1; reg_wdata = 16'h0100; acmd12_err = 6'b100000; step("R5");
    acmd12_err = 6'b100001; step("R5");
    acmd12_err = '0; reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    // R6 masks
    stat_en = 16'hFFEF; sig_en = 16'hFFFF; dat_timeout_ev = 1; cmd_err_ev = 4'b1000; step("R6");
    step("R10");
    stat_en = 16'h0000; adma_err_ev = 1; dat_crc_ev = 1; step("R6");
    stat_en = 16'hFFFF; sig_en = 16'h0000; dat_crc_ev = 1; step("R6");
    step("R10");
    sig_en = 16'h0020; step("R10");
    step("R10");
    reg_wr = 1; reg_wdata = 16'h0020; step("R10");
    step("R10");
    // R8 set vs clear same cycle
    dat_timeout_ev = 1; step("R8");
    dat_timeout_ev = 1; reg_wr = 1; reg_wdata = 16'h0010; step("R8");
    adma_err_ev = 1; reg_wr = 1; reg_wdata = 16'hFFFF; step("R8");
    // R9 reserved stay zero under every event and write
    cmd_err_ev = 4'hF; dat_timeout_ev = 1; dat_crc_ev = 1; rd_end_bit_err_ev = 1;
    adma_err_ev = 1; acmd12_err = 6'h3F; step("R9");
    reg_wr = 1; reg_wdata = 16'h0000; step("R9");
    sig_en = 16'hFC80; step("R9");
    step("R10");
    sig_en = 16'hFFFF; step("R10");
    reg_wr = 1; reg_wdata = 16'hFFFF; step("R7");
    step("R10");
    step("R10");
    // random mix
    for (int n = 0; n < 300; n++) begin
      cmd_err_ev = 4'($urandom_range(0, 15)) & {4{$urandom_range(0, 3) == 0}};
      dat_timeout_ev = ($urandom_range(0, 7) == 0);
      dat_crc_ev = ($urandom_range(0, 7) == 0);
      rd_end_bit_err_ev = ($urandom_range(0, 7) == 0);
      tok_valid = ($urandom_range(0, 3) == 0);
      tok_bits = 3'($urandom_range(0, 7));
      tok_end_bit = ($urandom_range(0, 3) != 0);
      adma_err_ev = ($urandom_range(0, 9) == 0);
      desc_fetch = ($urandom_range(0, 3) == 0);
      desc_valid = ($urandom_range(0, 2) != 0);
      acmd12_err = 6'($urandom_range(0, 63));
      reg_wr = ($urandom_range(0, 2) == 0);
      reg_wdata = 16'($urandom_range(0, 65535));
      if (n % 40 == 0) begin
        stat_en = 16'($urandom_range(0, 65535));
        sig_en = 16'($urandom_range(0, 65535));
      end
      step("R2");
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule